// File: doc/BRIEF.md
# Key-Gated Configuration Register Lock

This block keeps three sensitive configuration bytes behind a one-shot unlock. Software must first write a key byte to a dedicated key address. Only the protected write that comes right after the key takes effect, and only if the key matches the group that owns the target register. One key value opens the oscillator setup byte. A second key value opens the charger setup byte and the pin-control byte. After one write to any address other than the key address, the lock closes again. Writes to a locked register are dropped without any error indication.

The block stores the three protected bytes and serves them on a byte-wide read path. It also decodes their fields into plain control outputs: the oscillator source, the autocalibration enable and period, the charger enable, the diode type, the resistor setting, and the disable for an external input pin. The register port has a byte address, write data and a write strobe. Read data is combinational from the same address.

Top module: `cfg_lock_top`

## Requirements
- R1: After reset, all three protected bytes read 0x00, no group is unlocked, and every decoded output is 0.
- R2: A write of 0xA1 to address 0x1F, followed directly by a write to address 0x1C, stores that data in the oscillator byte.
- R3: A write of 0x9D to address 0x1F, followed directly by a write to 0x20 (charger byte) or 0x30 (pin-control byte), stores that data in the addressed byte.
- R4: A write to a protected address is ignored, and the stored byte keeps its value, when no unlock is active or when the active unlock belongs to the other group.
- R5: Any write to an address other than 0x1F ends the unlock, whether or not that write was accepted. Each unlock therefore permits at most one protected write.
- R6: A write to 0x1F of any value other than 0xA1 or 0x9D leaves every group locked. A new valid key replaces the group unlocked before it.
- R7: A read of 0x1F returns 0x00. A read of 0x1C, 0x20 or 0x30 returns the stored byte. A read of any other address returns 0x00.
- R8: Oscillator byte decode: bit 7 = 1 selects the RC source (`osc_rc_sel`). Bit 6 turns autocalibration on (`acal_on`). Bits 6:5 = 11 select the short 512-second period (`acal_short`). Bits 6:5 = 10 select the 1024-second period.
- R9: Charger byte decode: `chg_on` = 1 only when bits 7:4 = 0xA and bits 3:2 are 2 (standard diode) or 1 (Schottky diode). `chg_diode_std` and `chg_diode_schottky` report the diode type only while `chg_on` is 1. `chg_res_sel` always equals bits 1:0.
- R10: Pin-control byte decode: `ext_in_dis` equals bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the register port |
| addr | input | 8 | Register address, used for both write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Combinational read data for `addr` |
| osc_rc_sel | output | 1 | 1 selects the RC oscillator, 0 selects the crystal |
| acal_on | output | 1 | Autocalibration enabled |
| acal_short | output | 1 | Autocalibration uses the 512-second period |
| chg_on | output | 1 | Trickle charger enabled |
| chg_diode_std | output | 1 | Charger uses the standard diode |
| chg_diode_schottky | output | 1 | Charger uses the Schottky diode |
| chg_res_sel | output | 2 | Charger series resistor setting |
| ext_in_dis | output | 1 | Disables the external input pin |

## Verification
The assertions check four things on every cycle: any non-key write leaves the lock closed, a protected byte changes only on a write strobe aimed at it, the key address always reads as zero, and the decoded outputs never report an impossible combination. The bench scenarios cover what the assertions cannot. They write every possible key value, each followed by a write to each protected address, and check which of those writes are accepted. They also confirm that a second write after one unlock is refused and that a wrong-group key is refused. Finally, they sweep all 256 values of each protected byte through the decoders.

// File: rtl/cfg_lock_pkg.sv
package cfg_lock_pkg;

    // Which register group an unlock currently opens
    typedef enum logic [1:0] {
        GRP_NONE = 2'd0,
        GRP_OSC  = 2'd1,
        GRP_MISC = 2'd2
    } grp_e;

    // Protected register slots, fixed by function
    localparam int NUM_PROT = 3;
    localparam int IDX_OSC  = 0;
    localparam int IDX_TRK  = 1;
    localparam int IDX_OUT  = 2;

    // Charger field codes
    localparam logic [3:0] CHG_ENABLE_CODE = 4'hA;
    localparam logic [1:0] DIODE_STD_CODE  = 2'd2;
    localparam logic [1:0] DIODE_SCH_CODE  = 2'd1;

endpackage

// File: rtl/cfg_key_gate.sv
module cfg_key_gate
    import cfg_lock_pkg::*;
#(
    parameter int                ADDR_W   = 8,
    parameter int                DATA_W   = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR = 8'h1F,
    parameter logic [DATA_W-1:0] OSC_KEY  = 8'hA1,
    parameter logic [DATA_W-1:0] MISC_KEY = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output grp_e              grp_open
);

    typedef struct packed {
        grp_e grp;
    } gate_state_t;

    gate_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == KEY_ADDR) begin
                if (wdata == OSC_KEY) begin
                    st_d.grp = GRP_OSC;
                end else if (wdata == MISC_KEY) begin
                    st_d.grp = GRP_MISC;
                end else begin
                    st_d.grp = GRP_NONE;
                end
            end else begin
                // any other write consumes the unlock, accepted or not
                st_d.grp = GRP_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{grp: GRP_NONE};
        end else begin
            st_q <= st_d;
        end
    end

    assign grp_open = st_q.grp;

    AST_NONKEY_WRITE_RELOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr != KEY_ADDR) |=> (grp_open == GRP_NONE)); // R5

    AST_BAD_KEY_LOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == KEY_ADDR && wdata != OSC_KEY && wdata != MISC_KEY)
        |=> (grp_open == GRP_NONE)); // R6

endmodule

// File: rtl/cfg_prot_regs.sv
module cfg_prot_regs
    import cfg_lock_pkg::*;
#(
    parameter int                                ADDR_W    = 8,
    parameter int                                DATA_W    = 8,
    parameter int                                NREG      = 3,
    parameter logic [NREG-1:0][ADDR_W-1:0]       REG_ADDR  = '0,
    parameter logic [NREG-1:0][1:0]              REG_GRP   = '0
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    input  grp_e                         grp_open,
    output logic [NREG-1:0][DATA_W-1:0]  regs,
    output logic [DATA_W-1:0]            rdata
);

    typedef struct packed {
        logic [NREG-1:0][DATA_W-1:0] val;
    } regs_state_t;

    regs_state_t        st_d, st_q;
    logic [NREG-1:0]    addr_hit;
    logic [NREG-1:0]    wr_grant;

    for (genvar i = 0; i < NREG; i++) begin : g_slot
        assign addr_hit[i] = (addr == REG_ADDR[i]);
        assign wr_grant[i] = wr_en && addr_hit[i] && (grp_open == grp_e'(REG_GRP[i]));

        AST_LOCKED_REG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
            !(wr_en && addr_hit[i]) |=> $stable(regs[i])); // R4
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_grant[i]) begin
                st_d.val[i] = wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign regs = st_q.val;

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NREG; i++) begin
            if (addr_hit[i]) begin
                rdata = st_q.val[i];
            end
        end
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(wr_grant)); // R5

endmodule

// File: rtl/cfg_field_decode.sv
module cfg_field_decode
    import cfg_lock_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [DATA_W-1:0] osc_byte,
    input  logic [DATA_W-1:0] trk_byte,
    input  logic [DATA_W-1:0] out_byte,
    output logic              osc_rc_sel,
    output logic              acal_on,
    output logic              acal_short,
    output logic              chg_on,
    output logic              chg_diode_std,
    output logic              chg_diode_schottky,
    output logic [1:0]        chg_res_sel,
    output logic              ext_in_dis
);

    logic [3:0] chg_key;
    logic [1:0] diode_code;
    logic       diode_valid;

    always_comb begin
        osc_rc_sel = osc_byte[7];
        acal_on    = osc_byte[6];
        acal_short = (osc_byte[6:5] == 2'b11);
    end

    always_comb begin
        chg_key            = trk_byte[7:4];
        diode_code         = trk_byte[3:2];
        diode_valid        = (diode_code == DIODE_STD_CODE) || (diode_code == DIODE_SCH_CODE);
        chg_on             = (chg_key == CHG_ENABLE_CODE) && diode_valid;
        chg_diode_std      = chg_on && (diode_code == DIODE_STD_CODE);
        chg_diode_schottky = chg_on && (diode_code == DIODE_SCH_CODE);
        chg_res_sel        = trk_byte[1:0];
    end

    assign ext_in_dis = out_byte[4];

endmodule

// File: rtl/cfg_lock_top.sv
module cfg_lock_top
    import cfg_lock_pkg::*;
#(
    parameter int                ADDR_W    = 8,
    parameter int                DATA_W    = 8,
    parameter logic [ADDR_W-1:0] KEY_ADDR  = 8'h1F,
    parameter logic [ADDR_W-1:0] OSC_ADDR  = 8'h1C,
    parameter logic [ADDR_W-1:0] TRK_ADDR  = 8'h20,
    parameter logic [ADDR_W-1:0] OUT_ADDR  = 8'h30,
    parameter logic [DATA_W-1:0] OSC_KEY   = 8'hA1,
    parameter logic [DATA_W-1:0] MISC_KEY  = 8'h9D
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              osc_rc_sel,
    output logic              acal_on,
    output logic              acal_short,
    output logic              chg_on,
    output logic              chg_diode_std,
    output logic              chg_diode_schottky,
    output logic [1:0]        chg_res_sel,
    output logic              ext_in_dis
);

    localparam logic [NUM_PROT-1:0][ADDR_W-1:0] PROT_ADDR = {OUT_ADDR, TRK_ADDR, OSC_ADDR};
    localparam logic [NUM_PROT-1:0][1:0]        PROT_GRP  = {GRP_MISC, GRP_MISC, GRP_OSC};

    grp_e                              grp_open;
    logic [NUM_PROT-1:0][DATA_W-1:0]   regs;

    cfg_key_gate #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .KEY_ADDR (KEY_ADDR),
        .OSC_KEY  (OSC_KEY),
        .MISC_KEY (MISC_KEY)
    ) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .grp_open (grp_open)
    );

    cfg_prot_regs #(
        .ADDR_W   (ADDR_W),
        .DATA_W   (DATA_W),
        .NREG     (NUM_PROT),
        .REG_ADDR (PROT_ADDR),
        .REG_GRP  (PROT_GRP)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .addr     (addr),
        .wdata    (wdata),
        .grp_open (grp_open),
        .regs     (regs),
        .rdata    (rdata)
    );

    cfg_field_decode #(
        .DATA_W (DATA_W)
    ) u_dec (
        .osc_byte           (regs[IDX_OSC]),
        .trk_byte           (regs[IDX_TRK]),
        .out_byte           (regs[IDX_OUT]),
        .osc_rc_sel         (osc_rc_sel),
        .acal_on            (acal_on),
        .acal_short         (acal_short),
        .chg_on             (chg_on),
        .chg_diode_std      (chg_diode_std),
        .chg_diode_schottky (chg_diode_schottky),
        .chg_res_sel        (chg_res_sel),
        .ext_in_dis         (ext_in_dis)
    );

    AST_KEY_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == KEY_ADDR) |-> (rdata == '0)); // R7

    AST_SHORT_NEEDS_ACAL: assert property (@(posedge clk) disable iff (!rst_n)
        acal_short |-> acal_on); // R8

    AST_ONE_DIODE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({chg_diode_std, chg_diode_schottky})); // R9

endmodule

// File: tb/tb_cfg_lock_top.sv
`timescale 1ns/1ps
module tb_cfg_lock_top;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en;
    logic [7:0] addr;
    logic [7:0] wdata;
    logic [7:0] rdata;
    logic       osc_rc_sel, acal_on, acal_short;
    logic       chg_on, chg_diode_std, chg_diode_schottky;
    logic [1:0] chg_res_sel;
    logic       ext_in_dis;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    // Reference state built from the requirements: 0 none, 1 osc group, 2 misc group
    int         m_grp;
    logic [7:0] m_osc, m_trk, m_out;

    always #4 clk = ~clk;

    cfg_lock_top dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .osc_rc_sel(osc_rc_sel), .acal_on(acal_on),
        .acal_short(acal_short), .chg_on(chg_on), .chg_diode_std(chg_diode_std),
        .chg_diode_schottky(chg_diode_schottky), .chg_res_sel(chg_res_sel),
        .ext_in_dis(ext_in_dis)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic model_write(input logic [7:0] a, input logic [7:0] d);
        if (a == 8'h1F) begin
            m_grp = (d == 8'hA1) ? 1 : (d == 8'h9D) ? 2 : 0;
        end else begin
            if (a == 8'h1C && m_grp == 1) m_osc = d;
            if (a == 8'h20 && m_grp == 2) m_trk = d;
            if (a == 8'h30 && m_grp == 2) m_out = d;
            m_grp = 0;
        end
    endtask

    // drive at a falling edge, leave after the next falling edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(a, d);
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] v);
        addr = a; wr_en = 1'b0;
        #1;
        v = rdata;
    endtask

    function automatic logic [7:0] model_read(input logic [7:0] a);
        case (a)
            8'h1C:   return m_osc;
            8'h20:   return m_trk;
            8'h30:   return m_out;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_read(input logic [7:0] a, input string req);
        logic [7:0] v;
        rd(a, v);
        check(v == model_read(a), req, v, model_read(a));
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual 0x0 expected 0x1");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        logic [7:0] prot [3];
        prot[0] = 8'h1C; prot[1] = 8'h20; prot[2] = 8'h30;
        m_grp = 0; m_osc = 0; m_trk = 0; m_out = 0;
        rst_n = 1'b0; wr_en = 1'b0; addr = 8'h00; wdata = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        for (int i = 0; i < 3; i++) begin
            rd(prot[i], v);
            check(v == 8'h00, "R1 reset byte", v, 0);
        end
        check({osc_rc_sel, acal_on, acal_short, chg_on, chg_diode_std,
               chg_diode_schottky, chg_res_sel, ext_in_dis} == 9'd0,
              "R1 reset outputs", 0, 0);
        wr(8'h1C, 8'hFF);
        check_read(8'h1C, "R1 locked after reset");

        // R2 R3 R4 R6: every key value followed by a write to every protected byte
        for (int k = 0; k < 256; k++) begin
            for (int i = 0; i < 3; i++) begin
                wr(8'h1F, 8'(k));
                wr(prot[i], 8'(k) ^ (8'h5A + 8'(i)));
                check_read(prot[i], (k == 8'hA1 || k == 8'h9D) ? "R2/R3 key sweep" : "R4 R6 key sweep");
            end
        end

        // R5: single protected write per unlock
        wr(8'h1F, 8'hA1); wr(8'h1C, 8'h33); wr(8'h1C, 8'h44);
        check_read(8'h1C, "R5 second write refused");
        wr(8'h1F, 8'h9D); wr(8'h20, 8'hA9); wr(8'h30, 8'h10);
        check_read(8'h30, "R5 misc one write");
        check_read(8'h20, "R5 misc first write");
        // R5: write elsewhere consumes unlock
        wr(8'h1F, 8'h9D); wr(8'h05, 8'h77); wr(8'h30, 8'hEF);
        check_read(8'h30, "R5 unprotected write relocks");
        // R4: wrong group key
        wr(8'h1F, 8'hA1); wr(8'h20, 8'h00);
        check_read(8'h20, "R4 wrong group");
        // R6: key replaced by another key, then junk key
        wr(8'h1F, 8'hA1); wr(8'h1F, 8'h9D); wr(8'h1C, 8'h01);
        check_read(8'h1C, "R6 osc key replaced");
        wr(8'h1F, 8'h9D); wr(8'h1F, 8'h00); wr(8'h30, 8'h00);
        check_read(8'h30, "R6 junk key relocks");

        // R7: reads
        check_read(8'h1F, "R7 key reads zero");
        check_read(8'h05, "R7 unmapped reads zero");
        check_read(8'hFF, "R7 unmapped reads zero");

        // R8: oscillator decode sweep
        for (int x = 0; x < 256; x++) begin
            wr(8'h1F, 8'hA1); wr(8'h1C, 8'(x));
            check({osc_rc_sel, acal_on, acal_short} ==
                  {x[7], x[6], (x[6:5] == 2'b11)}, "R8 osc decode",
                  {osc_rc_sel, acal_on, acal_short}, {x[7], x[6], (x[6:5] == 2'b11)});
        end

        // R9: charger decode sweep
        for (int x = 0; x < 256; x++) begin
            bit on;
            wr(8'h1F, 8'h9D); wr(8'h20, 8'(x));
            on = (x[7:4] == 4'hA) && (x[3:2] == 2'd1 || x[3:2] == 2'd2);
            check({chg_on, chg_diode_std, chg_diode_schottky, chg_res_sel} ==
                  {on, on && x[3:2] == 2'd2, on && x[3:2] == 2'd1, x[1:0]},
                  "R9 charger decode",
                  {chg_on, chg_diode_std, chg_diode_schottky, chg_res_sel},
                  {on, on && x[3:2] == 2'd2, on && x[3:2] == 2'd1, x[1:0]});
        end

        // R10: pin-control decode sweep
        for (int x = 0; x < 256; x++) begin
            wr(8'h1F, 8'h9D); wr(8'h30, 8'(x));
            check(ext_in_dis == x[4], "R10 ext input disable", ext_in_dis, x[4]);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule